// File: doc/BRIEF.md
# Dummy-Read Bus Cycle Sequencer

This block produces the external bus transactions of a small 8-bit processor core for a group of indirect, direct-page and stack operations. A decoded operation class and the core's register values (program counter, stack pointer, Y index, direct-page base, status byte) are handed over with a start strobe. The sequencer then drives exactly one transaction per clock: an address, a read or write strobe and, on writes, the data. Bytes it reads are gathered into four operand latches (argument, word low, word high, data).

The bus never goes idle. Any clock the core spends internally is still shown as a read, flagged as a dummy. Such a read uses either the most recent genuinely read address or a stack address fixed by the operation. Data returned on a dummy read is thrown away. The flag lets side-effect registers, such as counters that clear when read, ignore these reads. Between operations the bus repeats a dummy read of the last genuine read address. A single-cycle done pulse closes each operation, and the next start is taken in the following cycle.

Top module: `dbseq_top`

## Requirements
- R1: Every clock shows exactly one of a read or a write. While no operation runs, the bus shows a dummy read (rd=1, dummy=1) of the last genuinely read address, which is 0 after reset.
- R2: Class 0 (indirect indexed by Y, read) takes 5 cycles, in this order. First, a read at PC gives the offset A. Next come reads of {DP,A} (pointer low) and {DP,A+1} (pointer high), with A+1 wrapping inside the page. Then a dummy read repeats {DP,A+1}. Last is a read at pointer+Y into the data latch.
- R3: Class 1 (indirect indexed by Y, modify) runs the R2 sequence and adds a sixth cycle. That cycle writes alu_wdata to pointer+Y, the same address the fifth cycle read.
- R4: Class 2 (direct-page store) takes 3 cycles: a read at PC gives A, then a dummy read of {DP,A}, then a write of alu_wdata to {DP,A}.
- R5: Every stack access uses address {8'h01, SP-relative byte}, with the low byte wrapping modulo 256.
- R6: Class 3 (return) takes 4 cycles. It begins with a dummy read of the last address, then a dummy read of {01,SP}. It then reads {01,SP+1} into word low and {01,SP+2} into word high. Class 4 (return from interrupt) has the same two opening dummy reads, then reads {01,SP+1} into the argument latch, {01,SP+2} into word low and {01,SP+3} into word high.
- R7: Class 5 (call) takes 6 cycles. It reads the target low byte at PC and the high byte at PC+1. It writes the high byte of PC+2 to {01,SP}, then the low byte of PC+2 to {01,SP-1}. It ends with two dummy reads of {01,SP-2}.
- R8: Class 6 (break) takes 6 cycles. It opens with a dummy read of the last address. It writes the PC high byte to {01,SP}, the PC low byte to {01,SP-1} and the status byte to {01,SP-2}. It then reads the vector low byte at BRK_VEC and the high byte at BRK_VEC+1.
- R9: Dummy reads never change the operand latches. When one address is read again within an operation, the value from the first read stays in the latch.
- R10: The last-address register changes only on genuine reads. Dummy reads, including those at stack addresses, and writes leave it unchanged.
- R11: op_done is high in the final cycle of each operation and only then. A start is taken only while busy is low. A start raised while an operation runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken while not busy) |
| op_sel | input | 3 | Operation class 0..6 |
| pc_in | input | 16 | Program counter at start |
| sp_in | input | 8 | Stack pointer at start |
| y_in | input | 8 | Y index at start |
| dpage_in | input | 8 | Direct-page base (high address byte) |
| psw_in | input | 8 | Status byte pushed by break |
| alu_wdata | input | 8 | Write-back data for modify and store |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_dummy | output | 1 | Current read is a dummy read |
| op_done | output | 1 | Final cycle of the operation |
| busy | output | 1 | Operation in progress |
| lat_arg | output | 8 | Argument latch |
| lat_lo | output | 8 | Word low latch |
| lat_hi | output | 8 | Word high latch |
| lat_dat | output | 8 | Data latch |

## Verification
Start is sampled at one rising edge, and the first transaction of the operation appears on the bus during the next clock. Each later cycle follows one clock after the one before. A latch takes its value at the edge that closes its read cycle and shows it from the following cycle on. The reference model therefore compares the bus at every falling edge against the next expected record of the operation's trace. It checks the latches at the idle falling edge after done. The bench returns a poisoned byte on every dummy read, so a latch that captures a dummy read shows a wrong value at that point.

// File: rtl/dbseq_pkg.sv
package dbseq_pkg;

   typedef enum logic [2:0] {
      OP_IDY_RD  = 3'd0,
      OP_IDY_RMW = 3'd1,
      OP_DP_ST   = 3'd2,
      OP_RET     = 3'd3,
      OP_RETI    = 3'd4,
      OP_CALL    = 3'd5,
      OP_BRK     = 3'd6
   } op_e;

   typedef enum logic [1:0] {K_READ, K_DUMMY, K_WRITE} kind_e;

   typedef enum logic [3:0] {
      A_PC0, A_PC1, A_DP0, A_DP1, A_LAST,
      A_SP0, A_SP1, A_SP2, A_SP3, A_SPM1, A_SPM2,
      A_PTRY, A_VEC0, A_VEC1
   } asrc_e;

   typedef enum logic [1:0] {W_ALU, W_RHI, W_RLO, W_PSW} wsrc_e;

   typedef enum logic [2:0] {L_NONE, L_ARG, L_LO, L_HI, L_DAT} lsel_e;

   typedef struct packed {
      kind_e kind;
      asrc_e asrc;
      wsrc_e wsrc;
      lsel_e lsel;
      logic  last;
   } step_t;

   function automatic step_t mk(kind_e k, asrc_e a, wsrc_e w, lsel_e l, logic e);
      step_t s;
      s.kind = k; s.asrc = a; s.wsrc = w; s.lsel = l; s.last = e;
      return s;
   endfunction

   localparam step_t IDLE_STEP = '{kind: K_DUMMY, asrc: A_LAST, wsrc: W_ALU, lsel: L_NONE, last: 1'b0};

   // per-class cycle schedule; index n counts cycles from zero
   function automatic step_t step_of(op_e op, logic [2:0] n);
      step_t s;
      s = mk(K_DUMMY, A_LAST, W_ALU, L_NONE, 1'b1);
      unique case (op)
         OP_IDY_RD, OP_IDY_RMW: begin
            case (n)
               3'd0: s = mk(K_READ,  A_PC0,  W_ALU, L_ARG,  1'b0);
               3'd1: s = mk(K_READ,  A_DP0,  W_ALU, L_LO,   1'b0);
               3'd2: s = mk(K_READ,  A_DP1,  W_ALU, L_HI,   1'b0);
               3'd3: s = mk(K_DUMMY, A_LAST, W_ALU, L_NONE, 1'b0);
               3'd4: s = mk(K_READ,  A_PTRY, W_ALU, L_DAT,  op == OP_IDY_RD);
               default: s = mk(K_WRITE, A_PTRY, W_ALU, L_NONE, 1'b1);
            endcase
         end
         OP_DP_ST: begin
            case (n)
               3'd0: s = mk(K_READ,  A_PC0, W_ALU, L_ARG,  1'b0);
               3'd1: s = mk(K_DUMMY, A_DP0, W_ALU, L_NONE, 1'b0);
               default: s = mk(K_WRITE, A_DP0, W_ALU, L_NONE, 1'b1);
            endcase
         end
         OP_RET, OP_RETI: begin
            case (n)
               3'd0: s = mk(K_DUMMY, A_LAST, W_ALU, L_NONE, 1'b0);
               3'd1: s = mk(K_DUMMY, A_SP0,  W_ALU, L_NONE, 1'b0);
               3'd2: s = (op == OP_RET) ? mk(K_READ, A_SP1, W_ALU, L_LO, 1'b0)
                                        : mk(K_READ, A_SP1, W_ALU, L_ARG, 1'b0);
               3'd3: s = (op == OP_RET) ? mk(K_READ, A_SP2, W_ALU, L_HI, 1'b1)
                                        : mk(K_READ, A_SP2, W_ALU, L_LO, 1'b0);
               default: s = mk(K_READ, A_SP3, W_ALU, L_HI, 1'b1);
            endcase
         end
         OP_CALL: begin
            case (n)
               3'd0: s = mk(K_READ,  A_PC0,  W_ALU, L_LO,   1'b0);
               3'd1: s = mk(K_READ,  A_PC1,  W_ALU, L_HI,   1'b0);
               3'd2: s = mk(K_WRITE, A_SP0,  W_RHI, L_NONE, 1'b0);
               3'd3: s = mk(K_WRITE, A_SPM1, W_RLO, L_NONE, 1'b0);
               3'd4: s = mk(K_DUMMY, A_SPM2, W_ALU, L_NONE, 1'b0);
               default: s = mk(K_DUMMY, A_SPM2, W_ALU, L_NONE, 1'b1);
            endcase
         end
         OP_BRK: begin
            case (n)
               3'd0: s = mk(K_DUMMY, A_LAST, W_ALU, L_NONE, 1'b0);
               3'd1: s = mk(K_WRITE, A_SP0,  W_RHI, L_NONE, 1'b0);
               3'd2: s = mk(K_WRITE, A_SPM1, W_RLO, L_NONE, 1'b0);
               3'd3: s = mk(K_WRITE, A_SPM2, W_PSW, L_NONE, 1'b0);
               3'd4: s = mk(K_READ,  A_VEC0, W_ALU, L_LO,   1'b0);
               default: s = mk(K_READ, A_VEC1, W_ALU, L_HI, 1'b1);
            endcase
         end
         default: s = mk(K_DUMMY, A_LAST, W_ALU, L_NONE, 1'b1);
      endcase
      return s;
   endfunction

endpackage

// File: rtl/dbseq_ctrl.sv
module dbseq_ctrl
   import dbseq_pkg::*;
#(
   parameter int DW = 8,
   localparam int AW = 2 * DW
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    op_in,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] sp_in,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] dpg_in,
   input  logic [DW-1:0] psw_in,
   output op_e           op_q,
   output step_t         step_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [AW-1:0] pc_q,
   output logic [DW-1:0] sp_q,
   output logic [DW-1:0] y_q,
   output logic [DW-1:0] dpg_q,
   output logic [DW-1:0] psw_q
);

   logic [2:0] cnt_q;

   always_comb begin
      step_o = busy_o ? step_of(op_q, cnt_q) : IDLE_STEP;
      done_o = busy_o & step_o.last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
         op_q   <= OP_IDY_RD;
         pc_q   <= '0;
         sp_q   <= '0;
         y_q    <= '0;
         dpg_q  <= '0;
         psw_q  <= '0;
      end else if (!busy_o) begin
         if (start) begin
            busy_o <= 1'b1;
            cnt_q  <= '0;
            op_q   <= op_e'(op_in);
            pc_q   <= pc_in;
            sp_q   <= sp_in;
            y_q    <= y_in;
            dpg_q  <= dpg_in;
            psw_q  <= psw_in;
         end
      end else if (done_o) begin
         busy_o <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 3'd1;
      end
   end

   // R11: an operation ends with done and the next cycle is idle
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   // R11: a running operation keeps its class until done
   p_op_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> (busy_o && $stable(op_q)));

endmodule

// File: rtl/dbseq_agen.sv
module dbseq_agen
   import dbseq_pkg::*;
#(
   parameter int DW = 8,
   parameter logic [DW-1:0] STACK_PAGE = 'h01,
   parameter logic [2*DW-1:0] BRK_VEC = 'hFFDE,
   localparam int AW = 2 * DW
)(
   input  asrc_e         asrc,
   input  wsrc_e         wsrc,
   input  op_e           op,
   input  logic [AW-1:0] pc_q,
   input  logic [DW-1:0] sp_q,
   input  logic [DW-1:0] y_q,
   input  logic [DW-1:0] dpg_q,
   input  logic [DW-1:0] psw_q,
   input  logic [DW-1:0] arg_q,
   input  logic [DW-1:0] lo_q,
   input  logic [DW-1:0] hi_q,
   input  logic [AW-1:0] last_q,
   input  logic [DW-1:0] alu_wdata,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o
);

   localparam logic [DW-1:0] ONE  = DW'(1);
   localparam logic [DW-1:0] TWO  = DW'(2);
   localparam logic [DW-1:0] THR  = DW'(3);
   localparam logic [DW-1:0] ZERO = '0;
   localparam logic [AW-1:0] W1   = AW'(1);
   localparam logic [AW-1:0] W2   = AW'(2);

   logic [AW-1:0] ret_w;
   logic [AW-1:0] ptr_y;
   logic [DW-1:0] sp_lo;

   always_comb begin
      ret_w = (op == OP_CALL) ? pc_q + W2 : pc_q;
      ptr_y = {hi_q, lo_q} + {ZERO, y_q};
      unique case (asrc)
         A_SP1:   sp_lo = sp_q + ONE;
         A_SP2:   sp_lo = sp_q + TWO;
         A_SP3:   sp_lo = sp_q + THR;
         A_SPM1:  sp_lo = sp_q - ONE;
         A_SPM2:  sp_lo = sp_q - TWO;
         default: sp_lo = sp_q;
      endcase
      unique case (asrc)
         A_PC0:   addr_o = pc_q;
         A_PC1:   addr_o = pc_q + W1;
         A_DP0:   addr_o = {dpg_q, arg_q};
         A_DP1:   addr_o = {dpg_q, arg_q + ONE};
         A_SP0, A_SP1, A_SP2, A_SP3, A_SPM1, A_SPM2:
                  addr_o = {STACK_PAGE, sp_lo};
         A_PTRY:  addr_o = ptr_y;
         A_VEC0:  addr_o = BRK_VEC;
         A_VEC1:  addr_o = BRK_VEC + W1;
         default: addr_o = last_q;
      endcase
      unique case (wsrc)
         W_RHI:   wdata_o = ret_w[AW-1:DW];
         W_RLO:   wdata_o = ret_w[DW-1:0];
         W_PSW:   wdata_o = psw_q;
         default: wdata_o = alu_wdata;
      endcase
   end

endmodule

// File: rtl/dbseq_latch.sv
module dbseq_latch
   import dbseq_pkg::*;
#(
   parameter int DW = 8,
   parameter int NLAT = 4,
   localparam int AW = 2 * DW
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  kind_e                    kind,
   input  lsel_e                    lsel,
   input  logic [AW-1:0]            addr,
   input  logic [DW-1:0]            rdata,
   output logic [NLAT-1:0][DW-1:0]  bank_q,
   output logic [AW-1:0]            last_q
);

   logic genuine;
   assign genuine = (kind == K_READ);

   for (genvar i = 0; i < NLAT; i++) begin : g_lat
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank_q[i] <= '0;
         else if (genuine && lsel == lsel_e'(i + 1))
            bank_q[i] <= rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         last_q <= '0;
      else if (genuine)
         last_q <= addr;
   end

   // R9: dummy reads and writes leave every operand latch alone
   p_dummy_keeps_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != K_READ) |=> $stable(bank_q));
   // R10: the last-address register follows genuine reads only
   p_last_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != K_READ) |=> $stable(last_q));
   p_last_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_READ) |=> (last_q == $past(addr)));

endmodule

// File: rtl/dbseq_top.sv
module dbseq_top
   import dbseq_pkg::*;
#(
   parameter int DW = 8,
   parameter logic [DW-1:0] STACK_PAGE = 'h01,
   parameter logic [2*DW-1:0] BRK_VEC = 'hFFDE,
   localparam int AW = 2 * DW,
   localparam int NLAT = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    op_sel,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] sp_in,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] dpage_in,
   input  logic [DW-1:0] psw_in,
   input  logic [DW-1:0] alu_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic [AW-1:0] bus_addr,
   output logic          bus_rd,
   output logic          bus_wr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_dummy,
   output logic          op_done,
   output logic          busy,
   output logic [DW-1:0] lat_arg,
   output logic [DW-1:0] lat_lo,
   output logic [DW-1:0] lat_hi,
   output logic [DW-1:0] lat_dat
);

   if (DW < 4) begin : g_chk_dw
      $error("dbseq_top: DW must be at least 4");
   end
   if (BRK_VEC == {AW{1'b1}}) begin : g_chk_vec
      $error("dbseq_top: BRK_VEC+1 would wrap the address space");
   end

   op_e                     op_q;
   step_t                   st;
   logic [AW-1:0]           pc_q;
   logic [DW-1:0]           sp_q, y_q, dpg_q, psw_q;
   logic [NLAT-1:0][DW-1:0] bank;
   logic [AW-1:0]           last_q;

   dbseq_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_sel),
      .pc_in(pc_in), .sp_in(sp_in), .y_in(y_in), .dpg_in(dpage_in), .psw_in(psw_in),
      .op_q(op_q), .step_o(st), .busy_o(busy), .done_o(op_done),
      .pc_q(pc_q), .sp_q(sp_q), .y_q(y_q), .dpg_q(dpg_q), .psw_q(psw_q)
   );

   dbseq_agen #(.DW(DW), .STACK_PAGE(STACK_PAGE), .BRK_VEC(BRK_VEC)) u_agen (
      .asrc(st.asrc), .wsrc(st.wsrc), .op(op_q),
      .pc_q(pc_q), .sp_q(sp_q), .y_q(y_q), .dpg_q(dpg_q), .psw_q(psw_q),
      .arg_q(bank[0]), .lo_q(bank[1]), .hi_q(bank[2]), .last_q(last_q),
      .alu_wdata(alu_wdata), .addr_o(bus_addr), .wdata_o(bus_wdata)
   );

   dbseq_latch #(.DW(DW), .NLAT(NLAT)) u_lat (
      .clk(clk), .rst_n(rst_n), .kind(st.kind), .lsel(st.lsel),
      .addr(bus_addr), .rdata(bus_rdata), .bank_q(bank), .last_q(last_q)
   );

   assign bus_rd    = (st.kind != K_WRITE);
   assign bus_wr    = (st.kind == K_WRITE);
   assign bus_dummy = (st.kind == K_DUMMY);
   assign lat_arg   = bank[0];
   assign lat_lo    = bank[1];
   assign lat_hi    = bank[2];
   assign lat_dat   = bank[3];

   // R1: between operations the bus shows a dummy read
   p_idle_is_dummy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_rd && bus_dummy && !bus_wr));
   // R1: a dummy cycle is always a read
   p_dummy_reads_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dummy |-> (bus_rd && !bus_wr));
   // R4: a store writes the address it just dummy-read
   p_store_dummy_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && op_q == OP_DP_ST) |-> ($past(bus_dummy) && $past(bus_addr) == bus_addr));
   // R3: the write-back goes to the address of the genuine data read
   p_rmw_same_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && op_q == OP_IDY_RMW) |-> ($past(bus_rd) && !$past(bus_dummy) && $past(bus_addr) == bus_addr));
   // R5: pushes land in the stack page
   p_push_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (op_q == OP_CALL || op_q == OP_BRK)) |-> (bus_addr[AW-1:DW] == STACK_PAGE));
   // R11: done marks a single cycle
   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |=> !op_done);

endmodule

// File: tb/dbseq_top_tb.sv
`timescale 1ns/1ps
module dbseq_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [15:0] pc_in = 16'h0;
   logic [7:0]  sp_in = 8'h0, y_in = 8'h0, dpage_in = 8'h0, psw_in = 8'h0, alu_wdata = 8'h0;
   logic [7:0]  bus_rdata;
   logic [15:0] bus_addr;
   logic        bus_rd, bus_wr, bus_dummy, op_done, busy;
   logic [7:0]  bus_wdata, lat_arg, lat_lo, lat_hi, lat_dat;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [15:0] last_a = 16'h0;

   always #4 clk = ~clk;

   function automatic logic [7:0] mv(logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // memory model; dummy reads get a poisoned byte
   assign bus_rdata = bus_dummy ? 8'hEE : mv(bus_addr);

   dbseq_top u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .pc_in(pc_in), .sp_in(sp_in), .y_in(y_in), .dpage_in(dpage_in),
      .psw_in(psw_in), .alu_wdata(alu_wdata), .bus_rdata(bus_rdata),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_dummy(bus_dummy), .op_done(op_done), .busy(busy),
      .lat_arg(lat_arg), .lat_lo(lat_lo), .lat_hi(lat_hi), .lat_dat(lat_dat)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // kind: 0 genuine read, 1 dummy read, 2 write; checked now, then one cycle on
   task automatic cyc(string tag, logic [15:0] a, int kind, logic [7:0] wd, bit last);
      logic [31:0] got, exp;
      got = {bus_addr, bus_rd, bus_wr, bus_dummy, op_done, (bus_wr ? bus_wdata : 8'h00), 4'h0};
      exp = {a, kind != 2, kind == 2, kind == 1, last, (kind == 2 ? wd : 8'h00), 4'h0};
      chk(tag, got, exp);
      if (kind == 0) last_a = a;
      @(negedge clk);
   endtask

   task automatic begin_op(logic [2:0] op);
      cyc("R1 idle", last_a, 1, 8'h0, 1'b0);
      chk("R11 idle busy", {31'd0, busy}, 32'd0);
      start = 1'b1;
      op_sel = op;
   endtask

   task automatic launch();
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_idy(bit rmw);
      logic [7:0] a, lo, hi;
      logic [15:0] p;
      begin_op(rmw ? 3'd1 : 3'd0);
      launch();
      a = mv(pc_in);
      lo = mv({dpage_in, a});
      hi = mv({dpage_in, a + 8'd1});
      p = {hi, lo} + {8'h00, y_in};
      cyc("R2 fetch offset", pc_in, 0, 8'h0, 1'b0);
      cyc("R2 ptr low", {dpage_in, a}, 0, 8'h0, 1'b0);
      cyc("R2 ptr high", {dpage_in, a + 8'd1}, 0, 8'h0, 1'b0);
      cyc("R2 dummy reread", {dpage_in, a + 8'd1}, 1, 8'h0, 1'b0);
      cyc("R2 data read", p, 0, 8'h0, !rmw);
      if (rmw) cyc("R3 write back", p, 2, alu_wdata, 1'b1);
      chk("R9 arg latch", {24'd0, lat_arg}, {24'd0, a});
      chk("R9 ptr lo latch", {24'd0, lat_lo}, {24'd0, lo});
      chk("R9 ptr hi first read kept", {24'd0, lat_hi}, {24'd0, hi});
      chk("R2 data latch", {24'd0, lat_dat}, {24'd0, mv(p)});
   endtask

   task automatic run_store();
      logic [7:0] a;
      begin_op(3'd2);
      launch();
      a = mv(pc_in);
      cyc("R4 fetch", pc_in, 0, 8'h0, 1'b0);
      cyc("R4 dummy target", {dpage_in, a}, 1, 8'h0, 1'b0);
      cyc("R4 write target", {dpage_in, a}, 2, alu_wdata, 1'b1);
   endtask

   task automatic run_ret(bit reti);
      logic [15:0] s1, s2, s3;
      logic [7:0]  prev_arg;
      prev_arg = lat_arg;
      begin_op(reti ? 3'd4 : 3'd3);
      launch();
      s1 = {8'h01, sp_in + 8'd1};
      s2 = {8'h01, sp_in + 8'd2};
      s3 = {8'h01, sp_in + 8'd3};
      cyc("R6 dummy last", last_a, 1, 8'h0, 1'b0);
      cyc("R6 R5 dummy stack", {8'h01, sp_in}, 1, 8'h0, 1'b0);
      cyc("R6 R5 pull 1", s1, 0, 8'h0, 1'b0);
      cyc("R6 R5 pull 2", s2, 0, 8'h0, !reti);
      if (reti) begin
         cyc("R6 R5 pull 3", s3, 0, 8'h0, 1'b1);
         chk("R6 status latch", {24'd0, lat_arg}, {24'd0, mv(s1)});
         chk("R6 ret lo", {24'd0, lat_lo}, {24'd0, mv(s2)});
         chk("R6 ret hi", {24'd0, lat_hi}, {24'd0, mv(s3)});
      end else begin
         chk("R6 ret lo", {24'd0, lat_lo}, {24'd0, mv(s1)});
         chk("R6 ret hi", {24'd0, lat_hi}, {24'd0, mv(s2)});
         chk("R9 arg untouched", {24'd0, lat_arg}, {24'd0, prev_arg});
      end
   endtask

   task automatic run_call();
      logic [15:0] r;
      r = pc_in + 16'd2;
      begin_op(3'd5);
      launch();
      cyc("R7 target lo", pc_in, 0, 8'h0, 1'b0);
      cyc("R7 target hi", pc_in + 16'd1, 0, 8'h0, 1'b0);
      cyc("R7 R5 push hi", {8'h01, sp_in}, 2, r[15:8], 1'b0);
      cyc("R7 R5 push lo", {8'h01, sp_in - 8'd1}, 2, r[7:0], 1'b0);
      cyc("R7 R5 dummy stack 1", {8'h01, sp_in - 8'd2}, 1, 8'h0, 1'b0);
      cyc("R7 R5 dummy stack 2", {8'h01, sp_in - 8'd2}, 1, 8'h0, 1'b1);
      chk("R7 target latch lo", {24'd0, lat_lo}, {24'd0, mv(pc_in)});
      chk("R7 target latch hi", {24'd0, lat_hi}, {24'd0, mv(pc_in + 16'd1)});
   endtask

   task automatic run_brk();
      begin_op(3'd6);
      launch();
      cyc("R8 dummy last", last_a, 1, 8'h0, 1'b0);
      // R11: a start raised mid-operation must be ignored
      start = 1'b1;
      op_sel = 3'd3;
      cyc("R8 R5 push pc hi", {8'h01, sp_in}, 2, pc_in[15:8], 1'b0);
      start = 1'b0;
      cyc("R8 R11 push pc lo", {8'h01, sp_in - 8'd1}, 2, pc_in[7:0], 1'b0);
      cyc("R8 push status", {8'h01, sp_in - 8'd2}, 2, psw_in, 1'b0);
      cyc("R8 vector lo", 16'hFFDE, 0, 8'h0, 1'b0);
      cyc("R8 vector hi", 16'hFFDF, 0, 8'h0, 1'b1);
      chk("R8 vector latch lo", {24'd0, lat_lo}, {24'd0, mv(16'hFFDE)});
      chk("R8 vector latch hi", {24'd0, lat_hi}, {24'd0, mv(16'hFFDF)});
      chk("R11 idle after done", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R11 watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset rd", {31'd0, bus_rd}, 32'd1);
      chk("R1 reset addr", {16'd0, bus_addr}, 32'd0);
      chk("R11 reset done", {31'd0, op_done}, 32'd0);

      pc_in = 16'h1234; dpage_in = 8'h00; y_in = 8'h05; alu_wdata = 8'hC3;
      run_idy(1'b0);
      pc_in = 16'h00A5; dpage_in = 8'h02; y_in = 8'hF0;   // offset FF: pointer high wraps in page
      run_idy(1'b0);
      pc_in = 16'h4321; dpage_in = 8'h01; y_in = 8'h80; alu_wdata = 8'h3C;
      run_idy(1'b1);
      pc_in = 16'h0810; dpage_in = 8'h00; alu_wdata = 8'h99;
      run_store();
      sp_in = 8'hC0;
      run_ret(1'b0);
      sp_in = 8'hFE;                                      // pulls wrap to 00, 01
      run_ret(1'b1);
      pc_in = 16'h12FF; sp_in = 8'h01;                    // pushes wrap to FF
      run_call();
      pc_in = 16'hBEEF; sp_in = 8'h40; psw_in = 8'hA5;
      run_brk();
      cyc("R10 idle keeps last read", last_a, 1, 8'h0, 1'b0);
      run_ret(1'b0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule